// File: doc/BRIEF.md
# Addressed peripheral I/O port

This block sits between a processor-style register bus and a single byte-wide peripheral. The processor reaches it through a small address window. The upper address bits carry the port's identity, a middle field names the device to act on, and the two low bits pick a register. Writing the command register starts one of four command classes:
- a control action, passed to the device;
- a status test, which samples the device's power and fault lines;
- a read, which fetches one byte from the device into the port's buffer;
- a write, which sends the buffered byte to the device.

Each control, read or write command runs a simple handshake with the peripheral. The port pulses a strobe for one cycle, then waits for a ready pulse from the device. While it waits, the peripheral's slower pace does not hold up the bus. A single data byte is held between the two sides.

Progress shows in a status register. Software either polls that register or sets the mode bit so that a finished read raises an interrupt request. In that mode, reading the data register takes the interrupt and clears READY. Commands that arrive while a transfer is still running are dropped and leave a sticky overrun flag. A device that never answers ends the transfer after a parameterised number of cycles and sets ERROR.

Top module: `ioport_unit`

## Requirements
- R1: The port responds only when `bus_sel` is high and `bus_addr[7:4]` equals `MOD_ID` (default 4'hA). `bus_addr[3:2]` is the device field and `bus_addr[1:0]` the register: 0 command, 1 data, 2 status, 3 mode. A non-matching access changes no state and reads return 8'h00. Status after reset reads 8'h00.
- R2: A command write whose class `bus_wdata[1:0]` is 0 (control), 2 (read) or 3 (write), accepted while not busy, raises `per_stb` for exactly the one cycle after the write. On that cycle it presents `per_op` = class, `per_dev` = the device field and `per_arg` = `bus_wdata[7:2]`. Status BUSY (bit 1) is 1 and READY (bit 0) is 0 from that cycle until completion.
- R3: A `per_rdy` pulse on any cycle after the strobe while busy ends the transfer. From the next cycle BUSY is 0 and READY is 1, and a read-class transfer has stored `per_rdata` in the data register.
- R4: With mode bit 0 at 0 (polled), `irq` never rises and status bits change only through the bus and the handshake.
- R5: With mode bit 0 at 1, completion of a read raises `irq`, shown also as status bit 5. A bus read of the data register then clears `irq` and READY on the next cycle.
- R6: A control, read or write command issued while busy produces no strobe, leaves `per_op`/`per_dev`/`per_arg` unchanged and sets sticky OVERRUN (status bit 4). A mode write with bit 1 set clears OVERRUN and ERROR.
- R7: If no `per_rdy` arrives within `TIMEOUT` cycles after the strobe, BUSY clears, ERROR (status bit 2) is set and READY stays 0. A later `per_rdy` is ignored.
- R8: A command of class 1 (test) copies `per_power` into POWER (status bit 3) and sets ERROR if `per_fault` is high. It produces no strobe and does not change BUSY.
- R9: `per_wdata` shows the data register. Bus writes to the data register load it only while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | AW (8) | Port identity, device field, register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| per_stb | output | 1 | One-cycle command strobe to the device |
| per_op | output | 2 | Command class of the current transfer |
| per_dev | output | DW (2) | Device selected for the current transfer |
| per_arg | output | 6 | Command argument |
| per_wdata | output | 8 | Buffered byte toward the device |
| per_rdy | input | 1 | Device completion pulse |
| per_rdata | input | 8 | Byte from the device |
| per_power | input | 1 | Device power-present line |
| per_fault | input | 1 | Device fault line |

## Verification
A wrong busy or wait-count state shows at the ports within a cycle or two, as a missing or doubled strobe, or a stuck BUSY in the next status read. A bad timeout count shifts the moment ERROR appears by one or more cycles. A wrong interrupt or READY state appears on `irq` on the cycle after completion or after the data read. Because the reference model is compared on every clock, a drift in any held field (`per_op`, `per_wdata`, the buffer) is reported on the first cycle it differs, not only when software reads it.

// File: rtl/ioport_unit.sv
module ioport_unit #(
  parameter int AW      = 8,
  parameter int DW      = 2,
  parameter int MOD_ID  = 10,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq,
  output logic          per_stb,
  output logic [1:0]    per_op,
  output logic [DW-1:0] per_dev,
  output logic [5:0]    per_arg,
  output logic [7:0]    per_wdata,
  input  logic          per_rdy,
  input  logic [7:0]    per_rdata,
  input  logic          per_power,
  input  logic          per_fault
);
  localparam int IW = AW - DW - 2;
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          busy_q, ready_q, err_q, pwr_q, ovr_q, irq_q, ie_q, stb_q;
  logic [7:0]    buf_q, last_q;
  logic [1:0]    op_q;
  logic [DW-1:0] dev_q;
  logic [5:0]    arg_q;
  logic [CW-1:0] cnt_q;

  wire       hit     = bus_sel && (bus_addr[AW-1:DW+2] == IW'(MOD_ID));
  wire [1:0] reg_a   = bus_addr[1:0];
  wire [1:0] cls     = bus_wdata[1:0];
  wire       wr_cmd  = hit && bus_wr && reg_a == 2'd0;
  wire       wr_dat  = hit && bus_wr && reg_a == 2'd1;
  wire       rd_dat  = hit && !bus_wr && reg_a == 2'd1;
  wire       wr_mode = hit && bus_wr && reg_a == 2'd3;
  wire       is_test = wr_cmd && cls == 2'd1;
  wire       is_hs   = wr_cmd && cls != 2'd1;
  wire       accept  = is_hs && !busy_q;
  wire       reject  = is_hs && busy_q;
  wire       waiting = busy_q && !stb_q;
  wire       done    = waiting && per_rdy;
  wire       expire  = waiting && !per_rdy && cnt_q == CW'(TIMEOUT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ready_q <= 1'b0; err_q <= 1'b0; pwr_q <= 1'b0;
      ovr_q  <= 1'b0; irq_q   <= 1'b0; ie_q  <= 1'b0; stb_q <= 1'b0;
      buf_q  <= '0;   last_q  <= '0;   op_q  <= '0;   dev_q <= '0;
      arg_q  <= '0;   cnt_q   <= '0;
    end else begin
      stb_q <= accept;
      if (wr_mode) begin
        ie_q <= bus_wdata[0];
        if (bus_wdata[1]) begin
          err_q <= 1'b0;
          ovr_q <= 1'b0;
        end
      end
      if (rd_dat && ie_q) begin
        ready_q <= 1'b0;
        irq_q   <= 1'b0;
      end
      if (wr_dat && !busy_q) buf_q <= bus_wdata;
      if (wr_cmd) last_q <= bus_wdata;
      if (is_test) begin
        pwr_q <= per_power;
        if (per_fault) err_q <= 1'b1;
      end
      if (reject) ovr_q <= 1'b1;
      if (accept) begin
        op_q    <= cls;
        dev_q   <= bus_addr[DW+1:2];
        arg_q   <= bus_wdata[7:2];
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
        irq_q   <= 1'b0;
        cnt_q   <= '0;
      end else if (done) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
        if (op_q == 2'd2) begin
          buf_q <= per_rdata;
          if (ie_q) irq_q <= 1'b1;
        end
      end else if (expire) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else if (waiting) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (hit && !bus_wr) begin
      case (reg_a)
        2'd0:    bus_rdata = last_q;
        2'd1:    bus_rdata = buf_q;
        2'd2:    bus_rdata = {2'b00, irq_q, ovr_q, pwr_q, err_q, busy_q, ready_q};
        default: bus_rdata = {7'b0, ie_q};
      endcase
    end
  end

  assign irq       = irq_q;
  assign per_stb   = stb_q;
  assign per_op    = op_q;
  assign per_dev   = dev_q;
  assign per_arg   = arg_q;
  assign per_wdata = buf_q;
endmodule

// File: rtl/ioport_unit_chk.sv
module ioport_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic per_stb,
  input logic per_rdy,
  input logic irq,
  input logic busy,
  input logic ready,
  input logic ovr,
  input logic mode_ie
);
  a_r2_stb_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |=> !per_stb);

  a_r2_busy_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> (busy && !ready));

  a_r3_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !per_stb && per_rdy) |=> (!busy && ready));

  a_r4_irq_only_in_int_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> mode_ie);

  a_r5_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);

  a_r6_overrun_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(busy));
endmodule

bind ioport_unit ioport_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .per_stb(per_stb), .per_rdy(per_rdy), .irq(irq),
  .busy(busy_q), .ready(ready_q), .ovr(ovr_q), .mode_ie(ie_q)
);

// File: tb/sim_ioport_unit.sv
module sim_ioport_unit;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, per_stb;
  logic [1:0] per_op, per_dev;
  logic [5:0] per_arg;
  logic [7:0] per_wdata;
  logic       per_rdy = 1'b0, per_power = 1'b0, per_fault = 1'b0;
  logic [7:0] per_rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ioport_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .per_stb(per_stb), .per_op(per_op), .per_dev(per_dev),
    .per_arg(per_arg), .per_wdata(per_wdata), .per_rdy(per_rdy),
    .per_rdata(per_rdata), .per_power(per_power), .per_fault(per_fault)
  );

  // reference model state
  bit m_busy, m_ready, m_err, m_pwr, m_ovr, m_irq, m_ie, m_stb;
  byte unsigned m_buf, m_last;
  int m_op, m_dev, m_arg, m_wait;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_err = 0; m_pwr = 0; m_ovr = 0; m_irq = 0;
      m_ie = 0; m_stb = 0; m_buf = 0; m_last = 0; m_op = 0; m_dev = 0;
      m_arg = 0; m_wait = 0;
    end else begin
      automatic bit mine = bus_sel && bus_addr[7:4] == 4'hA;
      automatic int r = bus_addr[1:0];
      automatic bit was_busy = m_busy, was_stb = m_stb, was_ie = m_ie;
      m_stb = 0;
      if (mine && bus_wr && r == 3) begin
        m_ie = bus_wdata[0];
        if (bus_wdata[1]) begin m_err = 0; m_ovr = 0; end
      end
      if (mine && !bus_wr && r == 1 && was_ie) begin m_ready = 0; m_irq = 0; end
      if (mine && bus_wr && r == 1 && !was_busy) m_buf = bus_wdata;
      if (mine && bus_wr && r == 0) begin
        m_last = bus_wdata;
        if (bus_wdata[1:0] == 2'd1) begin
          m_pwr = per_power;
          if (per_fault) m_err = 1;
        end else if (was_busy) m_ovr = 1;
        else begin
          m_stb = 1; m_busy = 1; m_ready = 0; m_irq = 0; m_wait = 0;
          m_op = bus_wdata[1:0]; m_dev = bus_addr[3:2]; m_arg = bus_wdata[7:2];
        end
      end
      if (was_busy && !was_stb) begin
        if (per_rdy) begin
          m_busy = 0; m_ready = 1;
          if (m_op == 2) begin m_buf = per_rdata; if (was_ie) m_irq = 1; end
        end else if (m_wait == TMO - 1) begin
          m_busy = 0; m_err = 1;
        end else m_wait++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic int er;
      #2;
      er = 0;
      if (bus_sel && !bus_wr && bus_addr[7:4] == 4'hA)
        case (bus_addr[1:0])
          2'd0: er = m_last;
          2'd1: er = m_buf;
          2'd2: er = {m_irq, m_ovr, m_pwr, m_err, m_busy, m_ready};
          default: er = m_ie;
        endcase
      chk("R1 model bus_rdata", bus_rdata, er);
      chk("R2 model per_stb", per_stb, m_stb);
      chk("R2 model per_op", per_op, m_op);
      chk("R2 model per_dev", per_dev, m_dev);
      chk("R2 model per_arg", per_arg, m_arg);
      chk("R9 model per_wdata", per_wdata, m_buf);
      chk("R5 model irq", irq, m_irq);
    end
  end

  function automatic logic [7:0] adr(input logic [1:0] dev, input logic [1:0] r);
    return {4'hA, dev, r};
  endfunction

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #3 v = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pulse(input logic [7:0] d);
    @(negedge clk); per_rdy = 1; per_rdata = d;
    @(negedge clk); per_rdy = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    bread(adr(0, 2), v); chk("R1 reset status", v, 8'h00);
    #3 chk("R4 reset irq", irq, 0);

    bwr({4'h5, 2'd0, 2'd0}, 8'h02); #3 chk("R1 foreign write no strobe", per_stb, 0);

    bwr(adr(2, 0), 8'h16);
    #3 chk("R2 strobe", per_stb, 1); chk("R2 op", per_op, 2);
    chk("R2 dev", per_dev, 2); chk("R2 arg", per_arg, 5);
    bread(adr(0, 2), v); chk("R2 busy status", v, 8'h02);
    @(negedge clk); pulse(8'h3C);
    bread(adr(0, 2), v); chk("R3 ready status", v, 8'h01);
    #3 chk("R4 polled irq low", irq, 0);
    bread(adr(0, 1), v); chk("R3 read data", v, 8'h3C);
    bread({4'h5, 2'd0, 2'd1}, v); chk("R1 foreign read zero", v, 8'h00);
    bread(adr(0, 2), v); chk("R4 polled read keeps ready", v, 8'h01);

    bwr(adr(0, 3), 8'h01);
    bwr(adr(1, 0), 8'h02);
    pulse(8'h81);
    #3 chk("R5 irq raised", irq, 1);
    bread(adr(0, 2), v); chk("R5 status with irq", v, 8'h21);
    bread(adr(0, 1), v); chk("R5 data", v, 8'h81);
    #3 chk("R5 irq cleared", irq, 0);
    bread(adr(0, 2), v); chk("R5 ready cleared", v, 8'h00);

    bwr(adr(3, 1), 8'h5A);
    bwr(adr(3, 0), 8'h07);
    #3 chk("R9 per_wdata", per_wdata, 8'h5A); chk("R2 write op", per_op, 3);
    bwr(adr(1, 0), 8'h02);
    #3 chk("R6 no strobe when busy", per_stb, 0); chk("R6 op kept", per_op, 3);
    chk("R6 dev kept", per_dev, 3);
    bwr(adr(3, 1), 8'hFF);
    #3 chk("R9 buffer held while busy", per_wdata, 8'h5A);
    pulse(8'h00);
    bread(adr(0, 2), v); chk("R6 overrun status", v, 8'h11);
    #3 chk("R5 no irq on write", irq, 0);
    bwr(adr(0, 3), 8'h03);
    bread(adr(0, 2), v); chk("R6 overrun cleared", v, 8'h01);

    bwr(adr(0, 0), 8'h0C);
    #3 chk("R2 control strobe", per_stb, 1); chk("R2 control op", per_op, 0);
    repeat (TMO + 4) @(negedge clk);
    bread(adr(0, 2), v); chk("R7 timeout status", v, 8'h04);
    pulse(8'hEE);
    bread(adr(0, 2), v); chk("R7 late ready ignored", v, 8'h04);
    bread(adr(0, 1), v); chk("R7 buffer untouched", v, 8'h5A);

    bwr(adr(0, 3), 8'h02);
    per_power = 1;
    bwr(adr(0, 0), 8'h01);
    #3 chk("R8 test no strobe", per_stb, 0);
    bread(adr(0, 2), v); chk("R8 power seen", v, 8'h08);
    per_fault = 1;
    bwr(adr(0, 0), 8'h01);
    bread(adr(0, 2), v); chk("R8 fault sets error", v, 8'h0C);
    per_fault = 0; per_power = 0;
    bwr(adr(0, 0), 8'h01);
    bread(adr(0, 2), v); chk("R8 power drop error sticky", v, 8'h04);

    bwr(adr(0, 0), 8'h02);
    pulse(8'h11);
    #3 chk("R4 polled read completion no irq", irq, 0);
    bread(adr(0, 2), v); chk("R4 polled status", v, 8'h05);
    bread(adr(0, 1), v); chk("R3 second read data", v, 8'h11);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule